// File: doc/BRIEF.md
# Multi-Channel Test Pattern Transmitter

This block drives a 16-lane parallel transmit word. Each lane carries either the user data word, delayed by a fixed three clock cycles, or a test pattern that the block makes itself. One pattern is shared by all lanes and a 2-bit mode input chooses it: a pseudo-random bit stream, the same stream with a periodic frame marker word, a constant level, or a square wave.

A 16-bit source register holds one bit per lane and decides which lanes carry user data. Software or a sequencer loads it one byte at a time from an 8-bit bus. There are two load strobes, one for the upper eight lanes and one for the lower eight. User data and internal patterns both go through the same three-stage output pipeline. Because of this, moving a lane from one source to the other keeps the word alignment. A mixed setup is also possible, where some lanes loop user traffic and others send a test sequence.

Top module: `lane_pattern_tx`

## Requirements
- R1: A lane whose source bit is 1 outputs bit `user_data_i[n]` exactly three rising clock edges after the edge that sampled it, with no change to the value.
- R2: `mode_i` selects the internal pattern with this encoding: 2'b00 pseudo-random, 2'b01 pseudo-random with frame word, 2'b10 static level, 2'b11 square wave.
- R3: The pseudo-random stream follows x^7 + x^6 + 1. Each new bit is the XOR of the bits 6 and 7 positions back. It starts from a state of seven ones at reset and advances by 16 bits on every clock, whatever the mode. Within a word, lane 15 carries the earliest bit and lane 0 the latest.
- R4: In frame mode, the word 16'hF628 replaces the pseudo-random word once every 128 words. The first word generated after reset is a frame word. The stream keeps advancing under the frame word.
- R5: In static mode, every internally sourced lane carries the level of `static_level_i` as sampled on the same edge as the user data of that word.
- R6: In square wave mode, every internally sourced lane inverts on each word. The first word after reset is 0, and the phase runs freely whatever the mode.
- R7: When `load_hi_i` is high at a rising edge, bit k of `src_byte_i` becomes the source bit of lane 8+k.
- R8: When `load_lo_i` is high at a rising edge, bit k of `src_byte_i` becomes the source bit of lane k. If both strobes are high, both halves take the same byte.
- R9: While both strobes are low, the source register keeps its value. `src_byte_i` then has no effect on the output.
- R10: While `rst_ni` is low, all outputs are 0 and all source bits are 0 (internal pattern). The output stays 0 until the first generated word has passed through the pipeline.
- R11: A source bit loaded at edge k first applies to the word sampled at edge k+1. Lanes with different source bits in the same word each take their own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| user_data_i | input | 16 | User data word, one bit per lane |
| mode_i | input | 2 | Internal pattern select |
| static_level_i | input | 1 | Level sent by lanes in static mode |
| src_byte_i | input | 8 | Byte written into one half of the source register |
| load_hi_i | input | 1 | Load strobe for the source bits of lanes 15..8 |
| load_lo_i | input | 1 | Load strobe for the source bits of lanes 7..0 |
| lanes_o | output | 16 | Transmitted word, one bit per lane |

## Verification
The bench runs the pseudo-random mode long enough to pass several 128-word frame boundaries. A frame counter that is off by one, or a stream that stops while the frame word is sent, would then put the marker or the following bits in the wrong word. Byte loads go to each half on its own, then to both at once. The mixed lane patterns would show a swapped half or a wrong bit order within the byte. Strobe-free cycles with a changing bus catch a register that loads without its strobe. A second reset in mid-run checks that the seed, the square wave phase and the frame position all restart. A design whose internal and user paths had different latencies would fail at every change of source.

// File: rtl/lane_pattern_pkg.sv
package lane_pattern_pkg;

  typedef enum logic [1:0] {
    MODE_PRBS       = 2'b00,
    MODE_PRBS_FRAME = 2'b01,
    MODE_STATIC     = 2'b10,
    MODE_SQUARE     = 2'b11
  } tx_mode_e;

endpackage

// File: rtl/lpt_prbs_gen.sv
module lpt_prbs_gen #(
  parameter int LANES   = 16,
  parameter int PRBS_LEN = 7,
  parameter int PRBS_TAP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [LANES-1:0] word_o
);

  logic [PRBS_LEN-1:0] state_q, state_d, st;
  logic                fb;

  // lane LANES-1 receives the earliest bit of the word
  always_comb begin
    st = state_q;
    fb = 1'b0;
    word_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      fb        = st[PRBS_LEN-1] ^ st[PRBS_TAP-1];
      word_o[i] = fb;
      st        = {st[PRBS_LEN-2:0], fb};
    end
    state_d = st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '1;
    else         state_q <= state_d;
  end

  assert_prbs_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/lpt_pattern_sel.sv
module lpt_pattern_sel
  import lane_pattern_pkg::*;
#(
  parameter int          LANES        = 16,
  parameter int          FRAME_PERIOD = 128,
  parameter logic [15:0] FRAME_WORD   = 16'hF628
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tx_mode_e         mode_i,
  input  logic [LANES-1:0] prbs_word_i,
  input  logic             static_level_i,
  output logic [LANES-1:0] pat_o
);

  localparam int CNT_W = (FRAME_PERIOD > 1) ? $clog2(FRAME_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_PERIOD - 1);

  logic [CNT_W-1:0] frame_cnt_q;
  logic             sq_q;
  logic             frame_hit;
  logic             past_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_q  <= '0;
      sq_q         <= 1'b0;
      past_valid_q <= 1'b0;
    end else begin
      frame_cnt_q  <= (frame_cnt_q == CNT_LAST) ? '0 : frame_cnt_q + 1'b1;
      sq_q         <= ~sq_q;
      past_valid_q <= 1'b1;
    end
  end

  assign frame_hit = (frame_cnt_q == '0);

  always_comb begin
    unique case (mode_i)
      MODE_PRBS:       pat_o = prbs_word_i;
      MODE_PRBS_FRAME: pat_o = frame_hit ? LANES'(FRAME_WORD) : prbs_word_i;
      MODE_STATIC:     pat_o = {LANES{static_level_i}};
      MODE_SQUARE:     pat_o = {LANES{sq_q}};
      default:         pat_o = prbs_word_i;
    endcase
  end

  assert_frame_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_q == CNT_LAST) |=> (frame_cnt_q == '0));

  assert_square_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q |-> (sq_q != $past(sq_q)));

endmodule

// File: rtl/lpt_src_regs.sv
module lpt_src_regs #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] src_byte_i,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  output logic [LANES-1:0]  src_o
);

  logic [LANES-1:0] src_q;
  logic             past_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q        <= '0;
      past_valid_q <= 1'b0;
    end else begin
      past_valid_q <= 1'b1;
      if (load_lo_i) src_q[BYTE_W-1:0]     <= src_byte_i;
      if (load_hi_i) src_q[LANES-1:BYTE_W] <= src_byte_i;
    end
  end

  assign src_o = src_q;

  assert_src_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && !$past(load_hi_i) && !$past(load_lo_i)) |-> $stable(src_q));

  assert_src_load_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hi_i |=> (src_q[LANES-1:BYTE_W] == $past(src_byte_i)));

  assert_src_load_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lo_i |=> (src_q[BYTE_W-1:0] == $past(src_byte_i)));

endmodule

// File: rtl/lpt_out_pipe.sv
module lpt_out_pipe #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= din_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout_o = stage_q[DEPTH-1];

endmodule

// File: rtl/lane_pattern_tx.sv
module lane_pattern_tx
  import lane_pattern_pkg::*;
#(
  parameter int          LANES        = 16,
  parameter int          BYTE_W       = 8,
  parameter int          PIPE_DEPTH   = 3,
  parameter int          PRBS_LEN     = 7,
  parameter int          PRBS_TAP     = 6,
  parameter int          FRAME_PERIOD = 128,
  parameter logic [15:0] FRAME_WORD   = 16'hF628
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  user_data_i,
  input  logic [1:0]        mode_i,
  input  logic              static_level_i,
  input  logic [BYTE_W-1:0] src_byte_i,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  output logic [LANES-1:0]  lanes_o
);

  logic [LANES-1:0] prbs_word;
  logic [LANES-1:0] pat_word;
  logic [LANES-1:0] src;
  logic [LANES-1:0] mux_word;
  tx_mode_e         mode;

  assign mode = tx_mode_e'(mode_i);

  lpt_prbs_gen #(
    .LANES(LANES), .PRBS_LEN(PRBS_LEN), .PRBS_TAP(PRBS_TAP)
  ) u_prbs (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_o(prbs_word)
  );

  lpt_pattern_sel #(
    .LANES(LANES), .FRAME_PERIOD(FRAME_PERIOD), .FRAME_WORD(FRAME_WORD)
  ) u_pat (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .prbs_word_i(prbs_word), .static_level_i(static_level_i), .pat_o(pat_word)
  );

  lpt_src_regs #(
    .LANES(LANES), .BYTE_W(BYTE_W)
  ) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_byte_i(src_byte_i),
    .load_hi_i(load_hi_i), .load_lo_i(load_lo_i), .src_o(src)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mux_word[l] = src[l] ? user_data_i[l] : pat_word[l];
  end

  lpt_out_pipe #(
    .WIDTH(LANES), .DEPTH(PIPE_DEPTH)
  ) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(mux_word), .dout_o(lanes_o)
  );

  assert_reset_out_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (lanes_o == '0));

endmodule

// File: tb/lane_pattern_tx_tb.sv
module lane_pattern_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] user_data = '0;
  logic [1:0]  mode = 2'b00;
  logic        static_level = 1'b0;
  logic [7:0]  src_byte = '0;
  logic        load_hi = 1'b0;
  logic        load_lo = 1'b0;
  logic [15:0] lanes;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  lane_pattern_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .user_data_i(user_data), .mode_i(mode),
    .static_level_i(static_level), .src_byte_i(src_byte),
    .load_hi_i(load_hi), .load_lo_i(load_lo), .lanes_o(lanes)
  );

  // reference model
  logic [15:0] m_pipe [3];
  bit          m_hist [$];
  int          m_cnt;
  bit          m_sq;
  logic [15:0] m_src;
  logic [15:0] m_pw, m_pat, m_word;
  bit          m_nb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_pipe[i] = '0;
      m_hist.delete();
      repeat (7) m_hist.push_back(1'b1);
      m_cnt = 0;
      m_sq  = 1'b0;
      m_src = '0;
    end else begin
      for (int i = 15; i >= 0; i--) begin
        m_nb = m_hist[0] ^ m_hist[1];
        m_pw[i] = m_nb;
        m_hist.push_back(m_nb);
        void'(m_hist.pop_front());
      end
      case (mode)
        2'b00: m_pat = m_pw;
        2'b01: m_pat = (m_cnt == 0) ? 16'hF628 : m_pw;
        2'b10: m_pat = {16{static_level}};
        default: m_pat = {16{m_sq}};
      endcase
      m_word = (user_data & m_src) | (m_pat & ~m_src);
      m_pipe[2] = m_pipe[1];
      m_pipe[1] = m_pipe[0];
      m_pipe[0] = m_word;
      if (load_lo) m_src[7:0]  = src_byte;
      if (load_hi) m_src[15:8] = src_byte;
      m_cnt = (m_cnt + 1) % 128;
      m_sq  = ~m_sq;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: lanes_o actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) check(cur_req, lanes, rst_n ? m_pipe[2] : 16'h0000);
  end

  task automatic run(int n, bit rnd_user, bit rnd_bus);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_user) user_data = 16'($urandom);
      if (rnd_bus)  src_byte  = 8'($urandom);
    end
  endtask

  task automatic load(bit hi, bit lo, logic [7:0] b);
    @(negedge clk);
    src_byte = b; load_hi = hi; load_lo = lo;
    @(negedge clk);
    load_hi = 1'b0; load_lo = 1'b0; src_byte = 8'($urandom);
  endtask

  task automatic finish_tb();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #40000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_tb();
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(negedge clk);
    check("R10", lanes, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R3";  mode = 2'b00; run(40, 1, 0);
    cur_req = "R4";  mode = 2'b01; run(300, 1, 0);
    cur_req = "R5";  mode = 2'b10; static_level = 1'b1; run(10, 1, 0);
    static_level = 1'b0; run(10, 1, 0);
    cur_req = "R6";  mode = 2'b11; run(12, 1, 0);
    cur_req = "R7";  load(1, 0, 8'hA5); run(8, 1, 0);
    cur_req = "R8";  load(0, 1, 8'h3C); run(8, 1, 0);
    cur_req = "R9";  run(20, 1, 1);
    cur_req = "R11"; mode = 2'b00; load(1, 0, 8'h0F); run(6, 1, 0);
    cur_req = "R1";  load(1, 1, 8'hFF); run(20, 1, 1);
    cur_req = "R2";  mode = 2'b01; load(1, 1, 8'h00); run(140, 1, 0);
    cur_req = "R11"; load(0, 1, 8'h81); mode = 2'b10; static_level = 1'b1; run(6, 1, 0);
    // mid-run reset, off the clock edges
    @(posedge clk); #1 rst_n = 1'b0;
    cur_req = "R10";
    @(negedge clk); check("R10", lanes, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R4"; mode = 2'b01; run(200, 1, 1);
    cur_req = "R6"; mode = 2'b11; run(10, 1, 0);
    finish_tb();
  end

endmodule